// File: doc/BRIEF.md
# Cache Slice Select Hash Unit

This unit takes a physical byte address and splits it the way a sliced, shared last-level cache needs it: the byte position inside a 64-byte line, the set index inside a slice, the remaining upper bits as the tag, and a 2-bit number that picks one of four slices. The slice number is not taken from a plain address field. Each of its bits is the parity of a fixed group of address bits, and each group spans both the set field and the tag field. This spreads line traffic evenly over the slices.

The unit sits between an address source and the slice router. A valid strobe travels with the address. With the default parameter setting, every output passes through one register stage. The fields then appear one cycle after the address is presented, and they hold their values while no new address arrives. Setting the output-register parameter to zero makes the unit purely combinational.

Top module: `slice_hash_unit`

## Requirements
- R1: `offset_o` equals address bits [5:0] of the accepted address.
- R2: `set_o` equals address bits [16:6] of the accepted address (2048 sets per slice).
- R3: `tag_o` equals address bits [63:17] of the accepted address.
- R4: `slice_o[0]` is the XOR of address bits 33, 32, 30, 28, 27, 26, 25, 24, 22, 20, 18, 17, 16, 14, 12, 10 and 6.
- R5: `slice_o[1]` is the XOR of address bits 34, 33, 31, 29, 28, 26, 24, 23, 22, 21, 20, 19, 17, 15, 13, 11 and 7.
- R6: An address bit that appears in neither R4 nor R5 has no effect on `slice_o`. This covers bits [5:0], 8, 9 and [63:35].
- R7: Two addresses with the same set index can map to different slices. For example, address 0 maps to slice 0 and address 0x20000 (bit 17) maps to slice 3.
- R8: With the output register enabled, `valid_o` repeats `valid_i` one cycle later, and the fields of an address presented with `valid_i` high appear in that same following cycle.
- R9: With the output register enabled, a cycle with `valid_i` low leaves `offset_o`, `set_o`, `tag_o` and `slice_o` unchanged.
- R10: While `rst_ni` is low, `valid_o` is low and all field outputs are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Address strobe |
| addr_i | input | 64 | Physical byte address |
| valid_o | output | 1 | Output fields valid |
| offset_o | output | 6 | Byte position inside the line |
| set_o | output | 11 | Set index inside a slice |
| tag_o | output | 47 | Upper address bits |
| slice_o | output | 2 | Selected slice |

## Verification
A one-hot walk over all 64 address bits shows, bit by bit, which parity group each bit belongs to. It separates a bit missing from a group, or an extra bit in a group, from a correct tree, and it exposes field boundaries that are off by one. Pseudo-random addresses exercise many bits switching at once, which a wrongly paired reduction node would corrupt. Flipping each unused bit on top of random bases shows those bits are truly ignored. A same-set pair and a held-strobe sequence separate hashing from direct indexing and capture from free-running registers.

// File: rtl/slice_hash_pkg.sv
package slice_hash_pkg;
  localparam int ADDR_W   = 64;
  localparam int LINE_B   = 64;
  localparam int SETS     = 2048;
  localparam int SLICES   = 4;
  localparam int OFFSET_W = $clog2(LINE_B);
  localparam int SET_W    = $clog2(SETS);
  localparam int SLICE_W  = $clog2(SLICES);
  localparam int SET_LSB  = OFFSET_W;
  localparam int TAG_LSB  = OFFSET_W + SET_W;
  localparam int TAG_W    = ADDR_W - TAG_LSB;

  // one parity group per slice-number bit
  localparam logic [ADDR_W-1:0] SLICE_MASK [SLICE_W] = '{
    64'h0000_0003_5F57_5440,
    64'h0000_0006_B5FA_A880
  };

  typedef struct packed {
    logic [OFFSET_W-1:0] offset;
    logic [SET_W-1:0]    set;
    logic [TAG_W-1:0]    tag;
    logic [SLICE_W-1:0]  slice;
  } line_fields_t;
endpackage

// File: rtl/slice_addr_split.sv
module slice_addr_split
  import slice_hash_pkg::*;
(
  input  logic [ADDR_W-1:0]   addr_i,
  output logic [OFFSET_W-1:0] offset_o,
  output logic [SET_W-1:0]    set_o,
  output logic [TAG_W-1:0]    tag_o
);
  assign offset_o = addr_i[OFFSET_W-1:0];
  assign set_o    = addr_i[TAG_LSB-1:SET_LSB];
  assign tag_o    = addr_i[ADDR_W-1:TAG_LSB];
endmodule

// File: rtl/slice_parity_tree.sv
module slice_parity_tree #(
  parameter int              W    = 64,
  parameter logic [W-1:0]    MASK = '0
) (
  input  logic [W-1:0] bits_i,
  output logic         parity_o
);
  localparam int LVLS = (W > 1) ? $clog2(W) : 1;
  localparam int NP   = 1 << LVLS;

  logic [NP-1:0] leaf;
  assign leaf = NP'(bits_i & MASK);

  // balanced XOR tree, depth log2(W)
  for (genvar l = 0; l <= LVLS; l++) begin : g_lvl
    logic [(NP>>l)-1:0] node;
    if (l == 0) begin : g_leaf
      assign node = leaf;
    end else begin : g_red
      for (genvar k = 0; k < (NP >> l); k++) begin : g_x
        assign node[k] = g_lvl[l-1].node[2*k] ^ g_lvl[l-1].node[2*k+1];
      end
    end
  end

  assign parity_o = g_lvl[LVLS].node[0];
endmodule

// File: rtl/slice_hash.sv
module slice_hash
  import slice_hash_pkg::*;
(
  input  logic [ADDR_W-1:0]  addr_i,
  output logic [SLICE_W-1:0] slice_o
);
  for (genvar s = 0; s < SLICE_W; s++) begin : g_bit
    slice_parity_tree #(
      .W    (ADDR_W),
      .MASK (SLICE_MASK[s])
    ) u_tree (
      .bits_i   (addr_i),
      .parity_o (slice_o[s])
    );
  end
endmodule

// File: rtl/slice_out_stage.sv
module slice_out_stage
  import slice_hash_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         valid_i,
  input  line_fields_t fields_i,
  output logic         valid_o,
  output line_fields_t fields_o
);
  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_o  <= 1'b0;
        fields_o <= '0;
      end else begin
        valid_o <= valid_i;
        if (valid_i) fields_o <= fields_i;
      end
    end
  end else begin : g_comb
    logic unused_clk;
    assign unused_clk = clk_i ^ rst_ni;
    assign valid_o  = valid_i;
    assign fields_o = fields_i;
  end
endmodule

// File: rtl/slice_hash_unit.sv
module slice_hash_unit
  import slice_hash_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                valid_i,
  input  logic [ADDR_W-1:0]   addr_i,
  output logic                valid_o,
  output logic [OFFSET_W-1:0] offset_o,
  output logic [SET_W-1:0]    set_o,
  output logic [TAG_W-1:0]    tag_o,
  output logic [SLICE_W-1:0]  slice_o
);
  line_fields_t nxt, cur;

  slice_addr_split u_split (
    .addr_i   (addr_i),
    .offset_o (nxt.offset),
    .set_o    (nxt.set),
    .tag_o    (nxt.tag)
  );

  slice_hash u_hash (
    .addr_i  (addr_i),
    .slice_o (nxt.slice)
  );

  slice_out_stage #(.REG_OUT(REG_OUT)) u_out (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .valid_i  (valid_i),
    .fields_i (nxt),
    .valid_o  (valid_o),
    .fields_o (cur)
  );

  assign offset_o = cur.offset;
  assign set_o    = cur.set;
  assign tag_o    = cur.tag;
  assign slice_o  = cur.slice;
endmodule

// File: rtl/slice_hash_chk.sv
module slice_hash_chk #(
  parameter bit REG_OUT = 1'b1
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        valid_i,
  input logic [63:0] addr_i,
  input logic        valid_o,
  input logic [5:0]  offset_o,
  input logic [10:0] set_o,
  input logic [46:0] tag_o,
  input logic [1:0]  slice_o
);
  function automatic logic [1:0] exp_slice(logic [63:0] a);
    exp_slice[0] = a[33]^a[32]^a[30]^a[28]^a[27]^a[26]^a[25]^a[24]^a[22]
                 ^ a[20]^a[18]^a[17]^a[16]^a[14]^a[12]^a[10]^a[6];
    exp_slice[1] = a[34]^a[33]^a[31]^a[29]^a[28]^a[26]^a[24]^a[23]^a[22]
                 ^ a[21]^a[20]^a[19]^a[17]^a[15]^a[13]^a[11]^a[7];
  endfunction

  if (REG_OUT) begin : g_seq
    a_r8_valid_lat: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_i |=> valid_o);
    a_r8_idle_lat: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !valid_i |=> !valid_o);
    a_r1_offset: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_i |=> offset_o == $past(addr_i[5:0]));
    a_r2_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_i |=> set_o == $past(addr_i[16:6]));
    a_r3_tag: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_i |=> tag_o == $past(addr_i[63:17]));
    a_r4_r5_slice: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_i |=> slice_o == exp_slice($past(addr_i)));
    a_r9_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !valid_i |=> $stable({offset_o, set_o, tag_o, slice_o}));
    always @(posedge clk_i) begin
      if (!rst_ni) begin
        a_r10_reset: assert (!valid_o && {offset_o, set_o, tag_o, slice_o} == '0);
      end
    end
  end else begin : g_comb
    always @(posedge clk_i) begin
      if (rst_ni && valid_i) begin
        a_r4_r5_comb: assert (slice_o == exp_slice(addr_i));
      end
    end
  end
endmodule

bind slice_hash_unit slice_hash_chk #(.REG_OUT(REG_OUT)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .valid_i  (valid_i),
  .addr_i   (addr_i),
  .valid_o  (valid_o),
  .offset_o (offset_o),
  .set_o    (set_o),
  .tag_o    (tag_o),
  .slice_o  (slice_o)
);

// File: tb/slice_hash_unit_bench.sv
`timescale 1ns/1ps
module slice_hash_unit_bench;
  logic        clk = 1'b0;
  logic        rst_ni;
  logic        valid_i;
  logic [63:0] addr_i;
  logic        valid_o;
  logic [5:0]  offset_o;
  logic [10:0] set_o;
  logic [46:0] tag_o;
  logic [1:0]  slice_o;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;
  logic [63:0] rng = 64'h9E37_79B9_7F4A_7C15;

  int grp0 [17] = '{33, 32, 30, 28, 27, 26, 25, 24, 22, 20, 18, 17, 16, 14, 12, 10, 6};
  int grp1 [17] = '{34, 33, 31, 29, 28, 26, 24, 23, 22, 21, 20, 19, 17, 15, 13, 11, 7};

  always #4 clk = ~clk;

  slice_hash_unit u_slice_hash_unit (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .addr_i(addr_i),
    .valid_o(valid_o), .offset_o(offset_o), .set_o(set_o), .tag_o(tag_o),
    .slice_o(slice_o)
  );

  function automatic bit in_grp(int g, int b);
    for (int i = 0; i < 17; i++) begin
      if (g == 0 && grp0[i] == b) return 1'b1;
      if (g == 1 && grp1[i] == b) return 1'b1;
    end
    return 1'b0;
  endfunction

  function automatic logic [1:0] ref_slice(logic [63:0] a);
    logic [1:0] r = 2'b00;
    for (int i = 0; i < 17; i++) begin
      r[0] = r[0] ^ a[grp0[i]];
      r[1] = r[1] ^ a[grp1[i]];
    end
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic next_rand(output logic [63:0] v);
    rng = rng ^ (rng << 13);
    rng = rng ^ (rng >> 7);
    rng = rng ^ (rng << 17);
    v = rng;
  endtask

  // present one address; returns at the negedge after the capturing edge
  task automatic send(input logic [63:0] a);
    @(negedge clk);
    addr_i  = a;
    valid_i = 1'b1;
    @(negedge clk);
  endtask

  task automatic check_all(input logic [63:0] a);
    check(valid_o == 1'b1, "R8 valid", 64'(valid_o), 64'd1);
    check(offset_o == a[5:0], "R1 offset", 64'(offset_o), 64'(a[5:0]));
    check(set_o == a[16:6], "R2 set", 64'(set_o), 64'(a[16:6]));
    check(tag_o == a[63:17], "R3 tag", 64'(tag_o), 64'(a[63:17]));
    check(slice_o[0] == ref_slice(a)[0], "R4 slice bit0", 64'(slice_o[0]), 64'(ref_slice(a)[0]));
    check(slice_o[1] == ref_slice(a)[1], "R5 slice bit1", 64'(slice_o[1]), 64'(ref_slice(a)[1]));
  endtask

  task automatic t_reset;
    #2;
    check(valid_o == 1'b0, "R10 valid in reset", 64'(valid_o), 64'd0);
    check({offset_o, set_o, tag_o, slice_o} == '0, "R10 fields in reset",
          64'({offset_o, set_o}), 64'd0);
  endtask

  task automatic t_walk;
    for (int b = 0; b < 64; b++) begin
      logic [63:0] a = 64'd1 << b;
      send(a);
      check_all(a);
      check(slice_o == {in_grp(1, b), in_grp(0, b)}, "R4 R5 walking bit",
            64'(slice_o), 64'({in_grp(1, b), in_grp(0, b)}));
    end
  endtask

  task automatic t_random;
    for (int n = 0; n < 200; n++) begin
      logic [63:0] a;
      next_rand(a);
      send(a);
      check_all(a);
    end
  endtask

  task automatic t_unused;
    for (int b = 0; b < 64; b++) begin
      if (!in_grp(0, b) && !in_grp(1, b)) begin
        for (int k = 0; k < 3; k++) begin
          logic [63:0] a;
          logic [1:0]  s_base;
          next_rand(a);
          send(a);
          s_base = slice_o;
          send(a ^ (64'd1 << b));
          check(slice_o == s_base, "R6 unused bit flip", 64'(slice_o), 64'(s_base));
        end
      end
    end
  endtask

  task automatic t_same_set;
    send(64'h0);
    check(slice_o == 2'd0, "R7 base slice", 64'(slice_o), 64'd0);
    send(64'h2_0000);
    check(set_o == 11'd0, "R7 same set", 64'(set_o), 64'd0);
    check(slice_o == 2'd3, "R7 other slice", 64'(slice_o), 64'd3);
  endtask

  task automatic t_latency;
    logic [63:0] a = 64'h0000_0005_1234_5678;
    @(negedge clk);
    valid_i = 1'b0;
    @(negedge clk);
    addr_i  = a;
    valid_i = 1'b1;
    #1;
    check(valid_o == 1'b0, "R8 no early valid", 64'(valid_o), 64'd0);
    @(negedge clk);
    check_all(a);
    valid_i = 1'b0;
    @(negedge clk);
    check(valid_o == 1'b0, "R8 valid drops", 64'(valid_o), 64'd0);
  endtask

  task automatic t_hold;
    logic [63:0] a = 64'hFFFF_0000_A5A5_3C3C;
    logic [63:0] b = 64'h0000_FFFF_5A5A_C3C3;
    send(a);
    valid_i = 1'b0;
    addr_i  = b;
    @(negedge clk);
    @(negedge clk);
    check(valid_o == 1'b0, "R9 valid low", 64'(valid_o), 64'd0);
    check(offset_o == a[5:0] && set_o == a[16:6], "R9 hold offset set",
          64'({set_o, offset_o}), 64'(a[16:0]));
    check(tag_o == a[63:17], "R9 hold tag", 64'(tag_o), 64'(a[63:17]));
    check(slice_o == ref_slice(a), "R9 hold slice", 64'(slice_o), 64'(ref_slice(a)));
  endtask

  initial begin
    rst_ni  = 1'b0;
    valid_i = 1'b0;
    addr_i  = 64'h0;
    t_reset();
    #20;
    @(negedge clk);
    rst_ni = 1'b1;
    t_walk();
    t_random();
    t_unused();
    t_same_set();
    t_latency();
    t_hold();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: run did not complete actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule